// File: doc/BRIEF.md
# Multi-phase quad SPI command sequencer

This block is the master side of a serial flash link. Within one chip-select session it runs a chain of up to four phases, for example a command byte on one lane, an address on four lanes and a data read on four lanes. Each phase has its own descriptor. The descriptor picks the lane width, the direction, the bit order and the unit size, and a per-phase multiplier sets how many units the phase moves. Write data comes from a byte-wide transmit queue and read data goes into a byte-wide receive queue. Both queues sit inside the block.

The serial clock is paced by an external tick: each tick toggles the serial clock during a transfer. Software programs the descriptors, the multipliers and the index of the last phase, loads the transmit queue, and pulses start while enable is high. Dropping enable stops the chain at any point. Four sticky flags report the transfer events, and each flag is cleared by writing 1 to its bit.

Top module: `qspi_phase_seq`

## Requirements
- R1: After reset `cs_no` is 1, `sck_o` is 0, `busy_o` is 0, `seq_idx_o` is 0, all flags are 0 and the receive queue is empty.
- R2: Each descriptor is 7 bits wide and packs its fields as follows:
  - [1:0] lane mode
  - [2] read
  - [4:3] unit
  - [5] LSB first
  - [6] keep select

  Phase k takes `desc_i[7k+6:7k]` and `mult_i[8k+7:8k]`. A `start_i` pulse while `enable_i` is high runs phases 0 through `last_phase_i` in ascending order. During each phase, `seq_idx_o` shows that phase's index.
- R3: A phase moves unit × multiplier bytes, where unit 0, 1 and 2 mean 1, 2 and 4 bytes. A phase whose multiplier is 0 moves no bytes and makes no clock pulses.
- R4: Serial clock and lane timing:
  - `sck_o` idles low, and each `tick_i` during a byte toggles it.
  - Lanes change only while `sck_o` is low, and inputs are sampled on its rising edge.
  - Lane mode 0 (single) sends on IO0 and receives on IO1.
  - Lane mode 1 (dual) uses IO1:IO0, with the higher bit of each pair on IO1 and the pair holding bits 7:6 going first.
  - Lane mode 2 (quad) uses IO3:IO0, with the high nibble first.
- R5: Read and write phases:
  - In a write phase (read bit 0), the used lanes are driven (`io_oe_o` set), and bytes are taken from the transmit queue in order.
  - In a read phase (read bit 1), dual and quad lanes are released, while single mode keeps driving IO0 with ones.
  - A read phase consumes no transmit data and pushes each received byte to the receive queue, whose head appears on `rx_data_o`.
- R6: With LSB first set, a byte is sent as its bit-reversed value in the R4 order, and a received byte is bit-reversed before it is stored.
- R7: Chip select between and after phases:
  - If the finishing phase has keep select 1, `cs_no` stays low into the next phase.
  - If keep select is 0, `cs_no` goes high for exactly one clock and then returns low.
  - After the last phase, `cs_no` always goes high.
- R8: While `cs_no` is high and `idle_fix_en_i` is 1, IO0 is driven to `idle_fix_val_i` (`io_oe_o` = 0001). With fixing off, all lanes are released.
- R9: Flags are sticky and cleared by writing 1 to their bit in `flag_clr_i`. A set event in the same cycle as a clear wins. The flag bits are:
  - bit 0: chip select negated.
  - bit 1: the engine emptied the transmit queue.
  - bit 2: the last phase completed.
  - bit 3: the engine filled the receive queue.
- R10: Dropping `enable_i` while busy returns the engine to idle on the next clock. At that clock `cs_no` is high, `sck_o` is low and `seq_idx_o` is 0, and the negation flag is set while the end flag is not.
- R11: The engine does not clock a byte until it can complete it. A write byte waits for transmit data, and a read byte waits for receive space. While it waits, chip select stays low and `sck_o` makes no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Engine enable; low aborts |
| start_i | input | 1 | Start pulse for a chain |
| last_phase_i | input | 2 | Index of the final phase |
| desc_i | input | 28 | Four packed phase descriptors |
| mult_i | input | 32 | Four 8-bit unit multipliers |
| idle_fix_en_i | input | 1 | Drive IO0 while deselected |
| idle_fix_val_i | input | 1 | Level for IO0 while deselected |
| tick_i | input | 1 | Serial clock toggle strobe |
| tx_push_i | input | 1 | Write a byte to the transmit queue |
| tx_data_i | input | 8 | Byte to write |
| tx_full_o | output | 1 | Transmit queue full |
| rx_pop_i | input | 1 | Remove the receive queue head |
| rx_data_o | output | 8 | Receive queue head |
| rx_empty_o | output | 1 | Receive queue empty |
| flag_clr_i | input | 4 | Write-1-to-clear flag strobes |
| flags_o | output | 4 | Sticky status flags |
| seq_idx_o | output | 2 | Current phase index |
| busy_o | output | 1 | Chain in progress |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| io_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables |
| io_i | input | 4 | Lane input values |

## Verification
The bench checks every rising serial clock edge against a model of the chain. At each edge it compares lane values, enables and phase index, so a swapped pair in dual mode, a nibble order error, a missing bit reversal or a phase run out of order shows up as a mismatch at that edge. Chains mix keep-select settings, include a zero-multiplier phase and use slow ticks. A design that drops the one-clock deselect gap, merges phases wrongly or clocks a skipped phase produces a wrong gap count or extra edges. Further cases cover a transmit queue loaded only after start, an exactly filled receive queue and an abort in mid-read. A design that clocks garbage while starved, misses the full flag, or leaves chip select low or flags wrong after abort is reported.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int DESC_W  = 7;
  localparam int NUM_PH  = 4;
  localparam int FLG_CSNEG = 0;
  localparam int FLG_TXE   = 1;
  localparam int FLG_END   = 2;
  localparam int FLG_RXF   = 3;

  typedef enum logic [1:0] {LANE_X1 = 2'd0, LANE_X2 = 2'd1, LANE_X4 = 2'd2} lane_e;

  typedef struct packed {
    logic       keep;
    logic       lsb_first;
    logic [1:0] unit;
    logic       rd;
    lane_e      lanes;
  } phase_desc_t;

  typedef enum logic [2:0] {S_IDLE, S_PHASE, S_FETCH, S_SHIFT, S_GAP} seq_st_e;

  function automatic logic [7:0] bit_rev(input logic [7:0] v);
    for (int i = 0; i < 8; i++) bit_rev[i] = v[7-i];
  endfunction
endpackage

// File: rtl/qseq_fifo.sv
module qseq_fifo #(
  parameter int DEPTH = 8,  // power of two
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/qseq_lane_shift.sv
module qseq_lane_shift
  import qseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  input  logic       lsb_first_i,
  input  lane_e      lanes_i,
  input  logic       sample_i,
  input  logic       shift_i,
  input  logic [3:0] io_i,
  output logic [3:0] lanes_o,
  output logic [7:0] rx_byte_o
);
  logic [7:0] tx_sr, rx_sr;

  always_comb begin
    case (lanes_i)
      LANE_X2: lanes_o = {2'b00, tx_sr[7:6]};
      LANE_X4: lanes_o = tx_sr[7:4];
      default: lanes_o = {3'b000, tx_sr[7]};
    endcase
  end

  assign rx_byte_o = lsb_first_i ? bit_rev(rx_sr) : rx_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (load_i) begin
      tx_sr <= lsb_first_i ? bit_rev(load_byte_i) : load_byte_i;
      rx_sr <= '0;
    end else begin
      if (shift_i) begin
        case (lanes_i)
          LANE_X2: tx_sr <= {tx_sr[5:0], 2'b00};
          LANE_X4: tx_sr <= {tx_sr[3:0], 4'b0000};
          default: tx_sr <= {tx_sr[6:0], 1'b0};
        endcase
      end
      if (sample_i) begin
        case (lanes_i)
          LANE_X2: rx_sr <= {rx_sr[5:0], io_i[1:0]};
          LANE_X4: rx_sr <= {rx_sr[3:0], io_i};
          default: rx_sr <= {rx_sr[6:0], io_i[1]};
        endcase
      end
    end
  end
endmodule

// File: rtl/qspi_phase_seq.sv
module qspi_phase_seq
  import qseq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int MULT_W     = 8,
  localparam int CNT_W     = MULT_W + 3,
  localparam int FCW       = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     enable_i,
  input  logic                     start_i,
  input  logic [1:0]               last_phase_i,
  input  logic [NUM_PH*DESC_W-1:0] desc_i,
  input  logic [NUM_PH*MULT_W-1:0] mult_i,
  input  logic                     idle_fix_en_i,
  input  logic                     idle_fix_val_i,
  input  logic                     tick_i,
  input  logic                     tx_push_i,
  input  logic [7:0]               tx_data_i,
  output logic                     tx_full_o,
  input  logic                     rx_pop_i,
  output logic [7:0]               rx_data_o,
  output logic                     rx_empty_o,
  input  logic [3:0]               flag_clr_i,
  output logic [3:0]               flags_o,
  output logic [1:0]               seq_idx_o,
  output logic                     busy_o,
  output logic                     sck_o,
  output logic                     cs_no,
  output logic [3:0]               io_o,
  output logic [3:0]               io_oe_o,
  input  logic [3:0]               io_i
);
  phase_desc_t       desc [NUM_PH];
  logic [MULT_W-1:0] mult [NUM_PH];

  for (genvar g = 0; g < NUM_PH; g++) begin : g_unpack
    assign desc[g] = phase_desc_t'(desc_i[g*DESC_W +: DESC_W]);
    assign mult[g] = mult_i[g*MULT_W +: MULT_W];
  end

  seq_st_e    st_q, st_d;
  logic [1:0] ph_q, ph_d;
  logic [CNT_W-1:0] left_q, left_d, nbytes;
  logic [2:0] step_q, step_d, step_last;
  logic       sck_q, sck_d, cs_n_q, cs_n_d;
  logic [3:0] flags_q, flag_set;
  logic       end_evt, phase_end, byte_done;
  logic       tx_pop, rx_push, ld, smp, sft;
  logic [7:0] ld_byte, tx_dout, rx_byte;
  logic [3:0] lanes;
  logic       tx_empty, rx_full;
  logic [FCW-1:0] tx_cnt, rx_cnt;
  phase_desc_t cur;

  assign cur = desc[ph_q];

  always_comb begin
    case (cur.unit)
      2'd0:    nbytes = CNT_W'(mult[ph_q]);
      2'd1:    nbytes = CNT_W'(mult[ph_q]) << 1;
      default: nbytes = CNT_W'(mult[ph_q]) << 2;
    endcase
    case (cur.lanes)
      LANE_X2: step_last = 3'd3;
      LANE_X4: step_last = 3'd1;
      default: step_last = 3'd7;
    endcase
  end

  qseq_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk_i, .rst_ni, .push_i(tx_push_i), .din_i(tx_data_i), .pop_i(tx_pop),
    .dout_o(tx_dout), .count_o(tx_cnt), .full_o(tx_full_o), .empty_o(tx_empty));

  qseq_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk_i, .rst_ni, .push_i(rx_push), .din_i(rx_byte), .pop_i(rx_pop_i),
    .dout_o(rx_data_o), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty_o));

  qseq_lane_shift u_shift (
    .clk_i, .rst_ni, .load_i(ld), .load_byte_i(ld_byte), .lsb_first_i(cur.lsb_first),
    .lanes_i(cur.lanes), .sample_i(smp), .shift_i(sft), .io_i,
    .lanes_o(lanes), .rx_byte_o(rx_byte));

  // byte strobes
  always_comb begin
    tx_pop = 1'b0; rx_push = 1'b0; ld = 1'b0; smp = 1'b0; sft = 1'b0;
    ld_byte = 8'hFF;
    if (enable_i) begin
      if (st_q == S_FETCH) begin
        if (cur.rd) ld = !rx_full;
        else if (!tx_empty) begin
          ld = 1'b1; tx_pop = 1'b1; ld_byte = tx_dout;
        end
      end else if (st_q == S_SHIFT && tick_i) begin
        if (!sck_q) smp = 1'b1;
        else begin
          sft = 1'b1;
          rx_push = cur.rd && (step_q == step_last);
        end
      end
    end
  end

  assign byte_done = sft && (step_q == step_last);
  assign phase_end = (st_q == S_PHASE && nbytes == '0) ||
                     (byte_done && left_q == CNT_W'(1));

  always_comb begin
    st_d = st_q; ph_d = ph_q; left_d = left_q; step_d = step_q;
    sck_d = sck_q; cs_n_d = cs_n_q; end_evt = 1'b0;
    if (!enable_i) begin
      if (st_q != S_IDLE) begin
        st_d = S_IDLE; ph_d = '0; sck_d = 1'b0; cs_n_d = 1'b1; step_d = '0;
      end
    end else begin
      case (st_q)
        S_IDLE:  if (start_i) begin ph_d = '0; cs_n_d = 1'b0; st_d = S_PHASE; end
        S_PHASE: if (nbytes != '0) begin left_d = nbytes; st_d = S_FETCH; end
        S_FETCH: if (ld) begin st_d = S_SHIFT; step_d = '0; end
        S_SHIFT: begin
          if (smp) sck_d = 1'b1;
          if (sft) begin
            sck_d = 1'b0;
            if (byte_done) begin
              step_d = '0; left_d = left_q - 1'b1; st_d = S_FETCH;
            end else step_d = step_q + 1'b1;
          end
        end
        S_GAP:   begin cs_n_d = 1'b0; st_d = S_PHASE; end
        default: st_d = S_IDLE;
      endcase
      if (phase_end) begin
        if (ph_q >= last_phase_i) begin
          st_d = S_IDLE; ph_d = '0; cs_n_d = 1'b1; end_evt = 1'b1;
        end else begin
          ph_d = ph_q + 1'b1;
          if (cur.keep) st_d = S_PHASE;
          else begin cs_n_d = 1'b1; st_d = S_GAP; end
        end
      end
    end
  end

  always_comb begin
    flag_set = '0;
    flag_set[FLG_CSNEG] = !cs_n_q && cs_n_d;
    flag_set[FLG_TXE]   = tx_pop && (tx_cnt == FCW'(1));
    flag_set[FLG_END]   = end_evt;
    flag_set[FLG_RXF]   = rx_push && (rx_cnt == FCW'(FIFO_DEPTH - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; ph_q <= '0; left_q <= '0; step_q <= '0;
      sck_q <= 1'b0; cs_n_q <= 1'b1; flags_q <= '0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; left_q <= left_d; step_q <= step_d;
      sck_q <= sck_d; cs_n_q <= cs_n_d;
      flags_q <= (flags_q & ~flag_clr_i) | flag_set;
    end
  end

  always_comb begin
    io_oe_o = 4'b0000;
    io_o    = 4'b0000;
    if (!cs_n_q) begin
      case (cur.lanes)
        LANE_X2: io_oe_o = cur.rd ? 4'b0000 : 4'b0011;
        LANE_X4: io_oe_o = cur.rd ? 4'b0000 : 4'b1111;
        default: io_oe_o = 4'b0001;
      endcase
      io_o = lanes & io_oe_o;
    end else if (idle_fix_en_i) begin
      io_oe_o = 4'b0001;
      io_o    = {3'b000, idle_fix_val_i};
    end
  end

  assign flags_o   = flags_q;
  assign seq_idx_o = ph_q;
  assign busy_o    = (st_q != S_IDLE);
  assign sck_o     = sck_q;
  assign cs_no     = cs_n_q;

  a_r4_sck_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);
  a_r4_lanes_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(io_o));
  a_r7_one_clock_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_no) && busy_o && enable_i) |=> !cs_no);
  a_r9_end_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[FLG_END]) |-> (!busy_o && cs_no));
  a_r10_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !enable_i) |=> (cs_no && !busy_o && !sck_o));
  a_r11_rx_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |-> !rx_full);
endmodule

// File: tb/qspi_phase_seq_tb.sv
module qspi_phase_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic enable = 1'b1, start = 1'b0;
  logic [1:0] last_phase = '0;
  logic [27:0] desc_v;
  logic [31:0] mult_v;
  logic fix_en = 1'b0, fix_val = 1'b0, tick = 1'b1;
  logic tx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_data = '0;
  logic [3:0] flag_clr = '0;
  logic tx_full, rx_empty, busy, sck, cs_n;
  logic [7:0] rx_data;
  logic [3:0] flags, io_o, io_oe, io_in;
  logic [1:0] seq_idx;

  logic [6:0] cfg_desc [4];
  int cfg_mult [4];
  logic [7:0] tx_src [$];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      desc_v[k*7 +: 7] = cfg_desc[k];
      mult_v[k*8 +: 8] = 8'(cfg_mult[k]);
    end
  end

  int rise_n = 0;
  function automatic logic [3:0] slave_val(input int n);
    return 4'((n * 7 + 3) ^ (n >> 2));
  endfunction
  assign io_in = slave_val(rise_n);

  qspi_phase_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .start_i(start),
    .last_phase_i(last_phase), .desc_i(desc_v), .mult_i(mult_v),
    .idle_fix_en_i(fix_en), .idle_fix_val_i(fix_val), .tick_i(tick),
    .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_full_o(tx_full),
    .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_empty_o(rx_empty),
    .flag_clr_i(flag_clr), .flags_o(flags), .seq_idx_o(seq_idx),
    .busy_o(busy), .sck_o(sck), .cs_no(cs_n), .io_o(io_o), .io_oe_o(io_oe),
    .io_i(io_in));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction
  function automatic logic [6:0] mk(input bit keep, input bit lsb, input int unit,
                                     input bit rd, input int lanes);
    return {keep, lsb, 2'(unit), rd, 2'(lanes)};
  endfunction

  // tick pacing
  int tick_div = 1, tcnt = 0;
  always @(negedge clk) begin
    if (tick_div <= 1) tick = 1'b1;
    else begin
      tick = (tcnt == 0);
      tcnt = (tcnt + 1) % tick_div;
    end
  end

  // reference model queues
  logic [3:0] exp_io [$];
  logic [3:0] exp_oe [$];
  int         exp_ph [$];
  logic [7:0] exp_rx [$];
  int gap_exp, wr_bytes, rd_bytes;
  int gap_cnt = 0, bad_sck = 0;
  logic sck_prev = 1'b0;

  task automatic build_model();
    int n = 0;
    logic [7:0] txq [$];
    txq = tx_src;
    exp_io.delete(); exp_oe.delete(); exp_ph.delete(); exp_rx.delete();
    gap_exp = 0; wr_bytes = 0; rd_bytes = 0;
    for (int p = 0; p <= int'(last_phase); p++) begin
      logic [6:0] d = cfg_desc[p];
      int lanes = int'(d[1:0]);
      bit rd = d[2], lsb = d[5];
      int bpc = (lanes == 1) ? 2 : (lanes == 2) ? 4 : 1;
      int nb = (1 << int'(d[4:3])) * cfg_mult[p];
      for (int b = 0; b < nb; b++) begin
        logic [7:0] v, r;
        r = '0;
        if (rd) begin v = 8'hFF; rd_bytes++; end
        else begin v = txq.pop_front(); wr_bytes++; end
        if (lsb) v = rev8(v);
        for (int s = 0; s < 8 / bpc; s++) begin
          logic [3:0] bits, oe, sv;
          bits = 4'((v >> (8 - bpc * (s + 1))) & ((1 << bpc) - 1));
          oe = (bpc == 1) ? 4'b0001 : rd ? 4'b0000 : 4'((1 << bpc) - 1);
          exp_io.push_back(bits); exp_oe.push_back(oe); exp_ph.push_back(p);
          sv = slave_val(n);
          n++;
          if (bpc == 1) r = {r[6:0], sv[1]};
          else if (bpc == 2) r = {r[5:0], sv[1:0]};
          else r = {r[3:0], sv};
        end
        if (rd) exp_rx.push_back(lsb ? rev8(r) : r);
      end
      if (p < int'(last_phase) && !d[6]) gap_exp++;
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (sck && !sck_prev) begin
        if (exp_io.size() == 0)
          chk(1'b0, "R3", "unexpected sck edge", 1, 0);
        else begin
          logic [3:0] eio, eoe;
          int eph;
          eio = exp_io.pop_front(); eoe = exp_oe.pop_front(); eph = exp_ph.pop_front();
          chk((io_o & eoe) == (eio & eoe), "R4", "lane value at sck rise", int'(io_o), int'(eio));
          chk(io_oe == eoe, "R5", "lane enables at sck rise", int'(io_oe), int'(eoe));
          chk(int'(seq_idx) == eph && !cs_n, "R2", "phase index at sck rise", int'(seq_idx), eph);
        end
        rise_n++;
      end
      if (busy && cs_n) gap_cnt++;
      if (sck && cs_n) bad_sck++;
    end
    sck_prev = sck;
  end

  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic push_tx();
    foreach (tx_src[i]) begin
      @(negedge clk); tx_push = 1'b1; tx_data = tx_src[i];
    end
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    chk(!busy, "R2", "chain completes", int'(busy), 0);
  endtask

  task automatic drain_rx();
    while (exp_rx.size() > 0) begin
      logic [7:0] e = exp_rx.pop_front();
      chk(!rx_empty && rx_data == e, "R5", "received byte", int'(rx_data), int'(e));
      rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    end
    chk(rx_empty, "R5", "receive queue drained", int'(rx_empty), 1);
  endtask

  task automatic run(input int push_delay);
    build_model();
    gap_cnt = 0; bad_sck = 0; rise_n = 0;
    if (push_delay == 0) push_tx();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (push_delay > 0) begin
      int pend = exp_io.size();
      repeat (push_delay) @(negedge clk);
      chk(exp_io.size() == pend && busy && !cs_n && !sck, "R11",
          "no clocking while transmit queue empty", pend - exp_io.size(), 0);
      push_tx();
    end
    wait_idle();
    chk(exp_io.size() == 0, "R3", "all expected sck edges seen", exp_io.size(), 0);
    chk(gap_cnt == gap_exp, "R7", "deselect gap clocks", gap_cnt, gap_exp);
    chk(bad_sck == 0 && cs_n, "R7", "cs high after chain", bad_sck, 0);
    chk(flags[2] && flags[0], "R9", "end and negation flags", int'(flags), 5);
    chk(flags[1] == (wr_bytes > 0), "R9", "tx empty flag", int'(flags[1]), int'(wr_bytes > 0));
    chk(flags[3] == (rd_bytes >= 8), "R9", "rx full flag", int'(flags[3]), int'(rd_bytes >= 8));
    drain_rx();
    flag_clr = 4'hF; @(negedge clk); flag_clr = 4'h0;
    chk(flags == 4'h0, "R9", "flags cleared by write 1", int'(flags), 0);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin cfg_desc[k] = '0; cfg_mult[k] = 0; end
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !busy && seq_idx == 0 && flags == 0 && rx_empty,
        "R1", "reset state", int'({cs_n, sck, busy, flags}), 32'h40);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 idle fixing
    fix_en = 1'b1; fix_val = 1'b1; @(negedge clk);
    chk(io_oe == 4'b0001 && io_o[0], "R8", "idle fix high", int'({io_oe, io_o}), 8'h11);
    fix_val = 1'b0; @(negedge clk);
    chk(io_oe == 4'b0001 && !io_o[0], "R8", "idle fix low", int'({io_oe, io_o}), 8'h10);
    fix_en = 1'b0; @(negedge clk);
    chk(io_oe == 4'b0000, "R8", "idle fix off", int'(io_oe), 0);

    // single write MSB first, R4/R3
    last_phase = 2'd0; tick_div = 1;
    cfg_desc[0] = mk(0, 0, 0, 0, 0); cfg_mult[0] = 2;
    tx_src = '{8'hA5, 8'h3C};
    build_model();
    gap_cnt = 0; rise_n = 0; push_tx();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle();
    chk(exp_io.size() == 0, "R3", "two byte single write edges", exp_io.size(), 0);
    flag_clr = 4'b0100; @(negedge clk); flag_clr = 4'h0;
    chk(flags == 4'b0011, "R9", "clear only end flag", int'(flags), 3);
    flag_clr = 4'hF; @(negedge clk); flag_clr = 4'h0;

    // command + quad address + quad read, keep asserted (R2, R5, R7)
    last_phase = 2'd2; tick_div = 2;
    cfg_desc[0] = mk(1, 0, 0, 0, 0); cfg_mult[0] = 1;
    cfg_desc[1] = mk(1, 0, 1, 0, 2); cfg_mult[1] = 1;
    cfg_desc[2] = mk(1, 0, 2, 1, 2); cfg_mult[2] = 1;
    tx_src = '{8'h0B, 8'h12, 8'h34};
    run(0);

    // dual, LSB first, with deselect between phases (R6, R7)
    last_phase = 2'd1; tick_div = 3;
    cfg_desc[0] = mk(0, 1, 1, 0, 1); cfg_mult[0] = 1;
    cfg_desc[1] = mk(0, 1, 0, 1, 1); cfg_mult[1] = 3;
    tx_src = '{8'hC1, 8'h7E};
    run(0);

    // zero multiplier phase is skipped (R3)
    last_phase = 2'd3; tick_div = 1;
    cfg_desc[0] = mk(1, 0, 0, 0, 0); cfg_mult[0] = 1;
    cfg_desc[1] = mk(1, 0, 0, 0, 2); cfg_mult[1] = 0;
    cfg_desc[2] = mk(0, 0, 0, 1, 0); cfg_mult[2] = 2;
    cfg_desc[3] = mk(0, 0, 0, 0, 1); cfg_mult[3] = 1;
    tx_src = '{8'h9F, 8'h66};
    run(0);

    // single read filling the receive queue exactly (R5, R9)
    last_phase = 2'd0;
    cfg_desc[0] = mk(0, 0, 1, 1, 0); cfg_mult[0] = 4;
    tx_src = {};
    run(0);

    // write stall until data arrives (R11)
    cfg_desc[0] = mk(0, 0, 0, 0, 2); cfg_mult[0] = 3;
    tx_src = '{8'h11, 8'h22, 8'h33};
    run(40);

    // abort in mid read (R10)
    tick_div = 4;
    cfg_desc[0] = mk(1, 0, 2, 1, 2); cfg_mult[0] = 2;
    tx_src = {};
    build_model();
    rise_n = 0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(cs_n && !busy && !sck && seq_idx == 0, "R10", "abort returns to idle",
        int'({cs_n, busy, sck, seq_idx}), 8'h10);
    chk(flags[0] && !flags[2], "R10", "abort flags", int'(flags), 1);
    exp_io.delete(); exp_oe.delete(); exp_ph.delete(); exp_rx.delete();
    while (!rx_empty) begin rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; end
    flag_clr = 4'hF; @(negedge clk); flag_clr = 4'h0;
    enable = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n && !busy, "R10", "stays idle after re-enable", int'({cs_n, busy}), 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule